// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block is a circular queue that holds in-flight instructions for a speculative out-of-order core. The issue stage takes one entry per cycle in program order and receives its tag, which labels the entry for the rest of its life. Execution units report results by tag in any order. Consumers read results that are complete but not yet committed through two operand lookup ports. The entry at the head retires only after its result is complete, so architectural state changes strictly in program order.

Every entry records what kind of instruction it holds. A branch has no destination. A store names a memory address, and the store queue releases it at commit. A register operation, which covers ALU operations and loads, names a register, and the register file is written at commit. Exceptions and branch mispredictions travel with the result. They are acted on only when their entry reaches the head. At that point the faulting entry and every younger entry are discarded, and the flush output reports the event.

Top module: `rob_core`

## Requirements
- R1: The issue port returns the tail slot as the tag and stays ready while the queue has room. Tags are handed out in ascending order and wrap from DEPTH-1 back to 0.
- R2: When DEPTH entries are occupied, `iss_ready` is low and an issue request is ignored. The ignored request changes neither the returned tag nor the contents of any entry.
- R3: A result write marks its tagged entry complete. Results may arrive in any order, but the head commits no earlier than the cycle after its own result write, and never before older entries commit.
- R4: `cm_valid` is high while the head entry is complete and carries no exception or mispredict. In that cycle `cm_kind` (0 = branch, 1 = store, 2 = register operation), `cm_dest` and `cm_value` describe the head. The head then retires at the clock edge, one entry per cycle at most.
- R5: An operand lookup whose tag names a valid, complete entry returns hit with the stored value.
- R6: A lookup whose tag matches a result written in the same cycle returns hit with the value being written.
- R7: Once an entry has committed, a lookup of its tag returns no hit, and the consumer reads the register file instead.
- R8: An exception recorded on an entry raises no flush while that entry is not at the head.
- R9: When the head is complete with an exception, `fl_valid` is high, `fl_exc` is 1 and `fl_tag` gives the head tag. At the edge the head entry and every younger entry are discarded, even completed ones, and none of them ever commits. The queue becomes empty, and the next tag issued is the flushing tag plus one.
- R10: During a flush cycle `iss_ready` is low and an issue request is not accepted.
- R11: A branch entry that is complete with its mispredict flag set flushes in the same way as R9, but with `fl_exc` equal to 0.
- R12: After reset the queue is empty: `iss_ready` is 1, `iss_tag` is 0, and `cm_valid` and `fl_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | Instruction kind: 0 branch, 1 store, 2 register op |
| iss_dest | input | DEST_W | Register number or memory address |
| iss_ready | output | 1 | Issue accepted this cycle if requested |
| iss_tag | output | TAG_W | Tag given to the issuing instruction |
| wr_valid | input | 1 | Result write strobe |
| wr_tag | input | TAG_W | Entry receiving the result |
| wr_value | input | DATA_W | Result value |
| wr_exc | input | 1 | Result raised an exception |
| wr_misp | input | 1 | Branch was mispredicted |
| qa_tag | input | TAG_W | Operand lookup A tag |
| qa_hit | output | 1 | Lookup A found an uncommitted result |
| qa_value | output | DATA_W | Lookup A value |
| qb_tag | input | TAG_W | Operand lookup B tag |
| qb_hit | output | 1 | Lookup B found an uncommitted result |
| qb_value | output | DATA_W | Lookup B value |
| cm_valid | output | 1 | Head commits this cycle |
| cm_kind | output | 2 | Kind of committing entry |
| cm_dest | output | DEST_W | Destination of committing entry |
| cm_value | output | DATA_W | Value of committing entry |
| fl_valid | output | 1 | Head flushes the queue this cycle |
| fl_exc | output | 1 | Flush cause: 1 exception, 0 mispredict |
| fl_tag | output | TAG_W | Tag of the flushing entry |

## Verification
The bench builds the buffer with DEPTH = 4, DATA_W = 16 and DEST_W = 12. The small depth makes the full condition and the pointer wrap from slot 3 back to 0 reachable within a few issues, and it lets a flush land on a slot just below the wrap point. The narrow fields keep every expected destination and value short enough to write out directly.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_BR  = 2'd0,
    KIND_ST  = 2'd1,
    KIND_REG = 2'd2,
    KIND_RSV = 2'd3
  } kind_e;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             retire,
  input  logic             flush,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [TAG_W-1:0] head_n, tail_n;
  logic [CNT_W-1:0] count_n;
  logic             upd;

  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    head_n  = head;
    tail_n  = tail;
    count_n = count;
    upd     = alloc | retire | flush;
    if (flush) begin
      head_n  = bump(head);
      tail_n  = bump(head);
      count_n = '0;
    end else begin
      if (retire) head_n = bump(head);
      if (alloc)  tail_n = bump(tail);
      count_n = count + CNT_W'(alloc) - CNT_W'(retire);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (upd) begin
      head  <= head_n;
      tail  <= tail_n;
      count <= count_n;
    end
  end

  assign full = (count == CNT_W'(DEPTH));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  assert_occupancy_track_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (count == $past(count) + CNT_W'($past(alloc)) - CNT_W'($past(retire))));
endmodule

// File: rtl/rob_fwd.sv
module rob_fwd #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic [TAG_W-1:0]             q_tag,
  input  logic                         wr_ok,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [DATA_W-1:0]            wr_value,
  input  logic [DEPTH-1:0]             ent_valid,
  input  logic [DEPTH-1:0]             ent_done,
  input  logic [DEPTH-1:0][DATA_W-1:0] ent_value,
  output logic                         hit,
  output logic [DATA_W-1:0]            value
);
  logic same;

  always_comb begin
    same  = wr_ok && (wr_tag == q_tag);
    hit   = ent_valid[q_tag] && (ent_done[q_tag] || same);
    value = same ? wr_value : ent_value[q_tag];
  end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [1:0]        iss_kind,
  input  logic [DEST_W-1:0] iss_dest,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_value,
  input  logic              wr_exc,
  input  logic              wr_misp,
  input  logic [TAG_W-1:0]  qa_tag,
  output logic              qa_hit,
  output logic [DATA_W-1:0] qa_value,
  input  logic [TAG_W-1:0]  qb_tag,
  output logic              qb_hit,
  output logic [DATA_W-1:0] qb_value,
  output logic              cm_valid,
  output logic [1:0]        cm_kind,
  output logic [DEST_W-1:0] cm_dest,
  output logic [DATA_W-1:0] cm_value,
  output logic              fl_valid,
  output logic              fl_exc,
  output logic [TAG_W-1:0]  fl_tag
);
  import rob_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int NQ    = 2;

  logic [TAG_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             full, alloc, wr_ok;
  logic             h_done, h_exc, h_misp;

  logic [DEPTH-1:0]             e_valid, e_done, e_exc, e_misp;
  logic [DEPTH-1:0]             vld_n, done_n, exc_n, misp_n;
  logic [DEPTH-1:0]             ld_alloc, ld_wr, drop;
  kind_e                        e_kind [DEPTH];
  logic [DEPTH-1:0][DEST_W-1:0] e_dest;
  logic [DEPTH-1:0][DATA_W-1:0] e_value;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .retire(cm_valid),
    .flush(fl_valid), .head(head), .tail(tail), .count(count), .full(full)
  );

  // head decision: commit or flush
  always_comb begin
    h_done    = e_valid[head] && e_done[head];
    h_exc     = e_exc[head];
    h_misp    = e_misp[head] && (e_kind[head] == KIND_BR);
    fl_valid  = h_done && (h_exc || h_misp);
    fl_exc    = h_exc;
    fl_tag    = head;
    cm_valid  = h_done && !(h_exc || h_misp);
    cm_kind   = e_kind[head];
    cm_dest   = e_dest[head];
    cm_value  = e_value[head];
    iss_ready = !full && !fl_valid;
    iss_tag   = tail;
    alloc     = iss_valid && iss_ready;
    wr_ok     = wr_valid && !fl_valid;
  end

  // per-entry next state
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ld_alloc[i] = alloc && (tail == TAG_W'(i));
      ld_wr[i]    = wr_ok && (wr_tag == TAG_W'(i)) && e_valid[i];
      drop[i]     = fl_valid || (cm_valid && (head == TAG_W'(i)));
      vld_n[i]    = drop[i] ? 1'b0 : (ld_alloc[i] ? 1'b1 : e_valid[i]);
      done_n[i]   = ld_alloc[i] ? 1'b0 : (ld_wr[i] ? 1'b1 : e_done[i]);
      exc_n[i]    = ld_alloc[i] ? 1'b0 : (ld_wr[i] ? wr_exc : e_exc[i]);
      misp_n[i]   = ld_alloc[i] ? 1'b0 : (ld_wr[i] ? wr_misp : e_misp[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= '0;
      e_done  <= '0;
      e_exc   <= '0;
      e_misp  <= '0;
    end else begin
      e_valid <= vld_n;
      e_done  <= done_n;
      e_exc   <= exc_n;
      e_misp  <= misp_n;
    end
  end

  // payload registers, no reset, loaded under enables
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ld_alloc[i]) begin
        e_kind[i] <= kind_e'(iss_kind);
        e_dest[i] <= iss_dest;
      end
      if (ld_wr[i]) e_value[i] <= wr_value;
    end
  end

  // operand lookup ports
  logic [NQ-1:0][TAG_W-1:0]  q_tag;
  logic [NQ-1:0]             q_hit;
  logic [NQ-1:0][DATA_W-1:0] q_val;

  assign q_tag[0] = qa_tag;
  assign q_tag[1] = qb_tag;

  for (genvar p = 0; p < NQ; p++) begin : g_look
    rob_fwd #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fwd (
      .q_tag(q_tag[p]), .wr_ok(wr_ok), .wr_tag(wr_tag), .wr_value(wr_value),
      .ent_valid(e_valid), .ent_done(e_done), .ent_value(e_value),
      .hit(q_hit[p]), .value(q_val[p])
    );
  end

  assign qa_hit   = q_hit[0];
  assign qa_value = q_val[0];
  assign qb_hit   = q_hit[1];
  assign qb_value = q_val[1];

  assert_full_blocks_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !iss_ready);

  assert_commit_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |=> (head != $past(head)));

  assert_flush_resets_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |=> (tail == head));
endmodule

// File: tb/rob_core_test.sv
module rob_core_test;
  localparam int DEPTH = 4, DATA_W = 16, DEST_W = 12, TAG_W = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic iss_valid; logic [1:0] iss_kind; logic [DEST_W-1:0] iss_dest;
  logic iss_ready; logic [TAG_W-1:0] iss_tag;
  logic wr_valid; logic [TAG_W-1:0] wr_tag; logic [DATA_W-1:0] wr_value;
  logic wr_exc, wr_misp;
  logic [TAG_W-1:0] qa_tag, qb_tag;
  logic qa_hit, qb_hit; logic [DATA_W-1:0] qa_value, qb_value;
  logic cm_valid; logic [1:0] cm_kind; logic [DEST_W-1:0] cm_dest;
  logic [DATA_W-1:0] cm_value;
  logic fl_valid, fl_exc; logic [TAG_W-1:0] fl_tag;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) uut (.*);

  typedef struct packed {
    logic iv; logic [1:0] ik; logic [11:0] id;
    logic wv; logic [1:0] wt; logic [15:0] wd;
    logic [1:0] qa; logic [1:0] qb;
    logic ir; logic [1:0] it;
    logic cv; logic [1:0] ck; logic [11:0] cd; logic [15:0] cval;
    logic ha; logic [15:0] va; logic hb; logic [15:0] vb;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1,2'd2,12'h005, 1'b0,2'd0,16'h0000, 2'd0,2'd1, 1'b1,2'd0, 1'b0,2'd0,12'h000,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000},
    '{1'b1,2'd1,12'h100, 1'b1,2'd0,16'h1111, 2'd0,2'd1, 1'b1,2'd1, 1'b0,2'd0,12'h000,16'h0000, 1'b1,16'h1111, 1'b0,16'h0000},
    '{1'b1,2'd0,12'h000, 1'b0,2'd0,16'h0000, 2'd0,2'd1, 1'b1,2'd2, 1'b1,2'd2,12'h005,16'h1111, 1'b1,16'h1111, 1'b0,16'h0000},
    '{1'b0,2'd0,12'h000, 1'b1,2'd2,16'h0000, 2'd0,2'd2, 1'b1,2'd3, 1'b0,2'd0,12'h000,16'h0000, 1'b0,16'h0000, 1'b1,16'h0000},
    '{1'b0,2'd0,12'h000, 1'b1,2'd1,16'h2222, 2'd1,2'd2, 1'b1,2'd3, 1'b0,2'd0,12'h000,16'h0000, 1'b1,16'h2222, 1'b1,16'h0000},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0,16'h0000, 2'd1,2'd2, 1'b1,2'd3, 1'b1,2'd1,12'h100,16'h2222, 1'b1,16'h2222, 1'b1,16'h0000},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0,16'h0000, 2'd1,2'd2, 1'b1,2'd3, 1'b1,2'd0,12'h000,16'h0000, 1'b0,16'h0000, 1'b1,16'h0000},
    '{1'b0,2'd0,12'h000, 1'b0,2'd0,16'h0000, 2'd1,2'd2, 1'b1,2'd3, 1'b0,2'd0,12'h000,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    iss_valid = 0; iss_kind = 0; iss_dest = '0;
    wr_valid = 0; wr_tag = '0; wr_value = '0; wr_exc = 0; wr_misp = 0;
    qa_tag = '0; qb_tag = '0;
  endtask

  task automatic nxt();
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic issue(input logic [1:0] k, input logic [DEST_W-1:0] d);
    iss_valid = 1; iss_kind = k; iss_dest = d;
  endtask

  task automatic result(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] v,
                        input logic e, input logic m);
    wr_valid = 1; wr_tag = t; wr_value = v; wr_exc = e; wr_misp = m;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    #4;
    chk("R12 iss_ready", iss_ready, 1);
    chk("R12 iss_tag", iss_tag, 0);
    chk("R12 cm_valid", cm_valid, 0);
    chk("R12 fl_valid", fl_valid, 0);

    // table walk: in-order commit, forwarding, post-commit miss
    foreach (VECS[n]) begin
      nxt();
      iss_valid = VECS[n].iv; iss_kind = VECS[n].ik; iss_dest = VECS[n].id;
      wr_valid = VECS[n].wv; wr_tag = VECS[n].wt; wr_value = VECS[n].wd;
      qa_tag = VECS[n].qa; qb_tag = VECS[n].qb;
      #4;
      chk("R1 iss_ready", iss_ready, VECS[n].ir);
      chk("R1 iss_tag", iss_tag, VECS[n].it);
      chk("R4 cm_valid", cm_valid, VECS[n].cv);
      if (VECS[n].cv) begin
        chk("R4 cm_kind", cm_kind, VECS[n].ck);
        chk("R4 cm_dest", cm_dest, VECS[n].cd);
        chk("R4 cm_value", cm_value, VECS[n].cval);
      end
      chk("R9 fl_valid", fl_valid, 0);
      chk("R5 R6 R7 qa_hit", qa_hit, VECS[n].ha);
      if (VECS[n].ha) chk("R5 R6 qa_value", qa_value, VECS[n].va);
      chk("R5 R6 R7 qb_hit", qb_hit, VECS[n].hb);
      if (VECS[n].hb) chk("R5 R6 qb_value", qb_value, VECS[n].vb);
    end

    // full queue and wrap (R2, R1)
    nxt(); do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      issue(2'd2, DEST_W'(12'h0A0 + i));
      #4;
      chk("R1 ready while room", iss_ready, 1);
      chk("R1 ascending tag", iss_tag, i);
      nxt();
    end
    issue(2'd1, 12'hFFF);
    #4;
    chk("R2 full not ready", iss_ready, 0);
    chk("R2 full tag", iss_tag, 0);
    nxt();
    result(2'd0, 16'h00AA, 0, 0);
    #4;
    chk("R3 no commit in write cycle", cm_valid, 0);
    nxt();
    #4;
    chk("R3 commit after write", cm_valid, 1);
    chk("R2 entry untouched kind", cm_kind, 2);
    chk("R2 entry untouched dest", cm_dest, 12'h0A0);
    chk("R4 value", cm_value, 16'h00AA);
    nxt();
    #4;
    chk("R1 wrap ready", iss_ready, 1);
    chk("R1 wrap tag", iss_tag, 0);
    chk("R4 one per cycle", cm_valid, 0);

    // exception deferral and flush (R3, R8, R9, R10)
    nxt(); do_reset();
    issue(2'd2, 12'h001); nxt();
    issue(2'd2, 12'h002); nxt();
    issue(2'd2, 12'h003); nxt();
    result(2'd2, 16'h0033, 0, 0); nxt();
    result(2'd1, 16'h0022, 1, 0);
    #4;
    chk("R8 no flush yet", fl_valid, 0);
    nxt();
    result(2'd0, 16'h0011, 0, 0);
    #4;
    chk("R8 exc not at head", fl_valid, 0);
    chk("R3 younger done no commit", cm_valid, 0);
    nxt();
    #4;
    chk("R3 oldest commits first", cm_valid, 1);
    chk("R3 oldest dest", cm_dest, 12'h001);
    chk("R8 head clean", fl_valid, 0);
    nxt();
    issue(2'd2, 12'h0EE);
    #4;
    chk("R9 flush", fl_valid, 1);
    chk("R9 cause exc", fl_exc, 1);
    chk("R9 flush tag", fl_tag, 1);
    chk("R9 no commit", cm_valid, 0);
    chk("R10 not ready", iss_ready, 0);
    nxt();
    qa_tag = 2'd2;
    #4;
    chk("R9 discarded done entry", qa_hit, 0);
    chk("R10 tag after flush", iss_tag, 2);
    chk("R9 empty ready", iss_ready, 1);
    chk("R9 flush one cycle", fl_valid, 0);
    nxt();
    #4;
    chk("R9 younger never commits", cm_valid, 0);

    // mispredict (R11)
    issue(2'd0, 12'h000); nxt();
    issue(2'd2, 12'h007); nxt();
    result(2'd3, 16'h0077, 0, 0); nxt();
    result(2'd2, 16'h0000, 0, 1); nxt();
    #4;
    chk("R11 flush", fl_valid, 1);
    chk("R11 cause", fl_exc, 0);
    chk("R11 tag", fl_tag, 2);
    chk("R11 no commit", cm_valid, 0);
    nxt();
    qa_tag = 2'd3;
    #4;
    chk("R11 next tag", iss_tag, 3);
    chk("R11 younger gone", qa_hit, 0);
    chk("R11 no commit after", cm_valid, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule